// File: doc/BRIEF.md
# Two-Channel PWM Output Shaper with Shadowed Override

This block is the output stage of a two-channel pulse-width modulator. An external time base supplies a counter value, its direction, strobes that mark the zero and period points, and a tick enable. On each tick, each channel (A and B) looks at which events occurred and applies the action programmed for the strongest of them to its output level. The events are counter zero, counter period, and an up-counting match with either compare register. An action can set the level low, set it high, toggle it, or leave it alone. Channel A and channel B share the two compare registers and the period strobe. Each channel has its own action register.

A software override can hold either pin low or high for as long as it is active. The override is written into a shadow register. It is copied into the active register at a tick selected by a reload field: at zero, at period, at either of the two, or at every tick. While an override holds a pin, the channel's underlying event level keeps evolving. When the override is released, the pin shows that event level at the next tick.

A typical setup for normal polarity drives the pin high on zero and on period, and low on the channel's own up-count compare match. Inverted polarity swaps those levels.

Top module: `pwm_action_qual`

## Requirements
- R1: Action codes are 2 bits. 00 leaves the level unchanged, 01 drives it low, 10 drives it high, and 11 inverts it.
- R2: In a channel's action register, bits [1:0] act on the zero strobe and bits [3:2] on the period strobe. Bits [5:4] act when the counter equals compare A while counting up, and bits [9:8] when it equals compare B while counting up.
- R3: A compare match while counting down (`cnt_up`=0) triggers no compare action.
- R4: When several events fall on one tick, only the highest-priority event with a nonzero code acts. The priority order, highest first, is compare B, compare A, period, zero.
- R5: Nothing on the outputs changes in a cycle where `tick` is low.
- R6: The shadow override register holds channel A's code in bits [1:0] and channel B's code in bits [3:2]. 01 forces the pin low, 10 forces it high, and 00 or 11 leave the pin to the event level.
- R7: An active force low or force high overrides every event action while it stays active. The event level keeps updating underneath, and the pin shows it from the first tick after release.
- R8: The reload code in bits [7:6] of the reload register picks when the shadow override is copied to the active override on a tick. 00 copies at zero, 01 at period, 10 at either, and 11 at every tick.
- R9: With reload code 11, a pin takes an override written in an earlier cycle at the first tick that follows the write.
- R10: Reset drives both pins low and clears both compare registers, both action registers, the reload field, and the shadow and active override registers.
- R11: The write address selects compare A (0), compare B (1), action A (2), action B (3), shadow override (4), or reload control (5). Writes to addresses 6 and 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Time-base tick enable |
| cnt | input | 16 | Time-base counter value |
| cnt_up | input | 1 | 1 while the counter counts up |
| at_zero | input | 1 | Counter-at-zero strobe |
| at_prd | input | 1 | Counter-at-period strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| pwm_a | output | 1 | Channel A output pin |
| pwm_b | output | 1 | Channel B output pin |

## Verification
Two pairs of functions can land in the same cycle. The first pair is the event actions and an override reload. A tick can carry a zero or period strobe that both moves the event level and copies in a new override. The bench drives random strobes, writes and reload codes together, so the override's takeover and the level update hidden under it meet on one edge. The second pair is concurrent events resolved by priority. The bench sweeps every combination of the four action codes against every combination of zero, period, compare-A and compare-B events, including down-counting matches. Each pin is judged every cycle against an arithmetic model built from the priority and code rules.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;
    localparam int NCH     = 2;
    localparam int ACT_W   = 10;
    localparam int ZRO_LSB = 0;
    localparam int PRD_LSB = 2;
    localparam int CAU_LSB = 4;
    localparam int CBU_LSB = 8;
    localparam int FRC_W   = 2;
    localparam int RLD_LSB = 6;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TOG  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        FRC_OFF  = 2'b00,
        FRC_LOW  = 2'b01,
        FRC_HIGH = 2'b10,
        FRC_PASS = 2'b11
    } frc_e;

    typedef enum logic [1:0] {
        RLD_ZERO = 2'b00,
        RLD_PRD  = 2'b01,
        RLD_BOTH = 2'b10,
        RLD_NOW  = 2'b11
    } rld_e;

    localparam logic [2:0] ADDR_CMPA = 3'd0;
    localparam logic [2:0] ADDR_CMPB = 3'd1;
    localparam logic [2:0] ADDR_ACTA = 3'd2;
    localparam logic [2:0] ADDR_ACTB = 3'd3;
    localparam logic [2:0] ADDR_FRC  = 3'd4;
    localparam logic [2:0] ADDR_RLD  = 3'd5;
endpackage

// File: rtl/aq_regs.sv
module aq_regs
    import pwm_aq_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [AW-1:0]                wr_addr,
    input  logic [DW-1:0]                wr_data,
    output logic [CW-1:0]                cmp_a,
    output logic [CW-1:0]                cmp_b,
    output logic [NCH-1:0][ACT_W-1:0]    act,
    output logic [NCH-1:0][FRC_W-1:0]    frc_sh,
    output logic [1:0]                   rld
);
    typedef struct packed {
        logic [CW-1:0]             cmp_a;
        logic [CW-1:0]             cmp_b;
        logic [NCH-1:0][ACT_W-1:0] act;
        logic [NCH-1:0][FRC_W-1:0] frc_sh;
        logic [1:0]                rld;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_CMPA: r_d.cmp_a  = wr_data[CW-1:0];
                ADDR_CMPB: r_d.cmp_b  = wr_data[CW-1:0];
                ADDR_ACTA: r_d.act[0] = wr_data[ACT_W-1:0];
                ADDR_ACTB: r_d.act[1] = wr_data[ACT_W-1:0];
                ADDR_FRC: begin
                    for (int c = 0; c < NCH; c++) begin
                        r_d.frc_sh[c] = wr_data[c*FRC_W +: FRC_W];
                    end
                end
                ADDR_RLD:  r_d.rld = wr_data[RLD_LSB +: 2];
                default:   r_d = r_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cmp_a  = r_q.cmp_a;
    assign cmp_b  = r_q.cmp_b;
    assign act    = r_q.act;
    assign frc_sh = r_q.frc_sh;
    assign rld    = r_q.rld;

    // R11
    unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr > ADDR_RLD) |=> $stable(r_q));
endmodule

// File: rtl/aq_force.sv
module aq_force
    import pwm_aq_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      at_zero,
    input  logic                      at_prd,
    input  logic [1:0]                rld,
    input  logic [NCH-1:0][FRC_W-1:0] frc_sh,
    output logic [NCH-1:0][FRC_W-1:0] frc_next
);
    typedef struct packed {
        logic [NCH-1:0][FRC_W-1:0] frc;
    } frc_state_t;

    frc_state_t s_d, s_q;
    logic load;

    always_comb begin
        case (rld)
            RLD_ZERO: load = at_zero;
            RLD_PRD:  load = at_prd;
            RLD_BOTH: load = at_zero | at_prd;
            default:  load = 1'b1;
        endcase
        s_d = s_q;
        if (tick && load) s_d.frc = frc_sh;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign frc_next = s_d.frc;

    // R8
    reload_zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rld == RLD_ZERO && !at_zero) |=> $stable(s_q));
    // R9
    reload_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && rld == RLD_NOW) |=> (s_q.frc == $past(frc_sh)));
endmodule

// File: rtl/aq_chan.sv
module aq_chan
    import pwm_aq_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             at_zero,
    input  logic             at_prd,
    input  logic             cnt_up,
    input  logic [CW-1:0]    cnt,
    input  logic [CW-1:0]    cmp_a,
    input  logic [CW-1:0]    cmp_b,
    input  logic [ACT_W-1:0] act,
    input  logic [FRC_W-1:0] frc_next,
    output logic             pin
);
    typedef struct packed {
        logic lvl;
        logic pin;
    } chan_t;

    chan_t s_d, s_q;
    logic hit_a, hit_b;
    logic [1:0] code;

    always_comb begin
        hit_a = cnt_up && (cnt == cmp_a);
        hit_b = cnt_up && (cnt == cmp_b);
        code  = ACT_NONE;
        if (at_zero && act[ZRO_LSB +: 2] != ACT_NONE) code = act[ZRO_LSB +: 2];
        if (at_prd  && act[PRD_LSB +: 2] != ACT_NONE) code = act[PRD_LSB +: 2];
        if (hit_a   && act[CAU_LSB +: 2] != ACT_NONE) code = act[CAU_LSB +: 2];
        if (hit_b   && act[CBU_LSB +: 2] != ACT_NONE) code = act[CBU_LSB +: 2];

        s_d = s_q;
        if (tick) begin
            case (code)
                ACT_LOW:  s_d.lvl = 1'b0;
                ACT_HIGH: s_d.lvl = 1'b1;
                ACT_TOG:  s_d.lvl = ~s_q.lvl;
                default:  s_d.lvl = s_q.lvl;
            endcase
            case (frc_next)
                FRC_LOW:  s_d.pin = 1'b0;
                FRC_HIGH: s_d.pin = 1'b1;
                default:  s_d.pin = s_d.lvl;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pin = s_q.pin;

    // R5
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pin));
    // R7
    force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_next == FRC_LOW) |=> !pin);
    // R7
    force_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && frc_next == FRC_HIGH) |=> pin);
    // R3
    down_match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_up && !at_zero && !at_prd) |=> $stable(s_q.lvl));
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
    import pwm_aq_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 16,
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] cnt,
    input  logic          cnt_up,
    input  logic          at_zero,
    input  logic          at_prd,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          pwm_a,
    output logic          pwm_b
);
    logic [CW-1:0]                cmp_a, cmp_b;
    logic [NCH-1:0][ACT_W-1:0]    act;
    logic [NCH-1:0][FRC_W-1:0]    frc_sh, frc_next;
    logic [1:0]                   rld;
    logic [NCH-1:0]               pins;

    aq_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cmp_a(cmp_a), .cmp_b(cmp_b), .act(act),
        .frc_sh(frc_sh), .rld(rld)
    );

    aq_force u_force (
        .clk(clk), .rst_n(rst_n), .tick(tick), .at_zero(at_zero),
        .at_prd(at_prd), .rld(rld), .frc_sh(frc_sh), .frc_next(frc_next)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        aq_chan #(.CW(CW)) u_ch (
            .clk(clk), .rst_n(rst_n), .tick(tick), .at_zero(at_zero),
            .at_prd(at_prd), .cnt_up(cnt_up), .cnt(cnt), .cmp_a(cmp_a),
            .cmp_b(cmp_b), .act(act[g]), .frc_next(frc_next[g]),
            .pin(pins[g])
        );
    end

    assign pwm_a = pins[0];
    assign pwm_b = pins[1];

    // R10
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b));
endmodule

// File: tb/sim_pwm_action_qual.sv
`timescale 1ns/1ps
module sim_pwm_action_qual;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [15:0] cnt = '0;
    logic        cnt_up = 1'b0;
    logic        at_zero = 1'b0;
    logic        at_prd = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;

    // bench model state
    logic [15:0] m_cmp [2];
    logic [9:0]  m_act [2];
    logic [1:0]  m_sh  [2];
    logic [1:0]  m_frc [2];
    logic        m_lvl [2];
    logic        m_pin [2];
    logic [1:0]  m_rld;

    always #2.5 clk = ~clk;

    pwm_action_qual u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt(cnt), .cnt_up(cnt_up),
        .at_zero(at_zero), .at_prd(at_prd), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic chk(input string tag, input string what, input logic act_v, input logic exp_v);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s %s got %b expected %b at %0t", tag, what, act_v, exp_v, $time);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            m_cmp[c] = '0; m_act[c] = '0; m_sh[c] = '0;
            m_frc[c] = '0; m_lvl[c] = 1'b0; m_pin[c] = 1'b0;
        end
        m_rld = '0;
    endtask

    // R4 priority: compare B over compare A over period over zero; nonzero codes only
    function automatic logic [1:0] pick(input logic [9:0] a, input logic z, input logic p,
                                        input logic ma, input logic mb);
        logic [1:0] r;
        r = 2'b00;
        if (z  && a[1:0] != 2'b00) r = a[1:0];
        if (p  && a[3:2] != 2'b00) r = a[3:2];
        if (ma && a[5:4] != 2'b00) r = a[5:4];
        if (mb && a[9:8] != 2'b00) r = a[9:8];
        return r;
    endfunction

    task automatic step(input logic we, input logic [2:0] a, input logic [15:0] d,
                        input logic tk, input logic z, input logic p, input logic up,
                        input logic [15:0] c, input string tag);
        logic load;
        logic [1:0] code;
        wr_en = we; wr_addr = a; wr_data = d;
        tick = tk; at_zero = z; at_prd = p; cnt_up = up; cnt = c;
        if (tk) begin
            case (m_rld)
                2'b00: load = z;
                2'b01: load = p;
                2'b10: load = z | p;
                default: load = 1'b1;
            endcase
            for (int ch = 0; ch < 2; ch++) begin
                if (load) m_frc[ch] = m_sh[ch];
                code = pick(m_act[ch], z, p, up && c == m_cmp[0], up && c == m_cmp[1]);
                case (code)
                    2'b01: m_lvl[ch] = 1'b0;
                    2'b10: m_lvl[ch] = 1'b1;
                    2'b11: m_lvl[ch] = ~m_lvl[ch];
                    default: ;
                endcase
                m_pin[ch] = (m_frc[ch] == 2'b01) ? 1'b0 :
                            (m_frc[ch] == 2'b10) ? 1'b1 : m_lvl[ch];
            end
        end
        if (we) begin
            case (a)
                3'd0: m_cmp[0] = d;
                3'd1: m_cmp[1] = d;
                3'd2: m_act[0] = d[9:0];
                3'd3: m_act[1] = d[9:0];
                3'd4: begin m_sh[0] = d[1:0]; m_sh[1] = d[3:2]; end
                3'd5: m_rld = d[7:6];
                default: ;
            endcase
        end
        @(negedge clk);
        chk(tag, "pwm_a", pwm_a, m_pin[0]);
        chk(tag, "pwm_b", pwm_b, m_pin[1]);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
        step(1'b1, a, d, 1'b0, 1'b0, 1'b0, 1'b0, 16'd0, tag);
    endtask

    task automatic tk(input logic z, input logic p, input logic up, input logic [15:0] c,
                      input string tag);
        step(1'b0, 3'd0, 16'd0, 1'b1, z, p, up, c, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; tick = 1'b0;
        model_reset();
        @(negedge clk); @(negedge clk);
        chk("R10", "pwm_a reset", pwm_a, 1'b0);
        chk("R10", "pwm_b reset", pwm_b, 1'b0);
        rst_n = 1'b1;
    endtask

    initial begin
        #1ms;
        checks++; errors++;
        $display("FAIL watchdog expired R5 got hang expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        do_reset();

        // R1/R2 directed on channel A: zero sets high, then toggles, then drives low
        wr(3'd2, 16'h0002, "R2");
        tk(1'b1, 1'b0, 1'b1, 16'd3, "R1");
        chk("R1", "pwm_a high after zero", pwm_a, 1'b1);
        wr(3'd2, 16'h0003, "R1");
        tk(1'b1, 1'b0, 1'b1, 16'd3, "R1");
        chk("R1", "pwm_a toggled low", pwm_a, 1'b0);
        // normal polarity on A: high at zero/period, low at compare A up
        wr(3'd0, 16'd4, "R11");
        wr(3'd2, 16'h001A, "R2");
        tk(1'b1, 1'b0, 1'b1, 16'd0, "R2");
        chk("R2", "pwm_a high at zero", pwm_a, 1'b1);
        // R3 down-count match ignored
        tk(1'b0, 1'b0, 1'b0, 16'd4, "R3");
        chk("R3", "pwm_a stays on down match", pwm_a, 1'b1);
        tk(1'b0, 1'b0, 1'b1, 16'd4, "R2");
        chk("R2", "pwm_a low at compare A up", pwm_a, 1'b0);
        // R5 no tick, no change
        step(1'b0, 3'd0, 16'd0, 1'b0, 1'b0, 1'b1, 1'b1, 16'd0, "R5");
        chk("R5", "pwm_a holds without tick", pwm_a, 1'b0);
        // R11 unmapped writes ignored
        wr(3'd6, 16'hFFFF, "R11");
        wr(3'd7, 16'hFFFF, "R11");
        tk(1'b0, 1'b0, 1'b1, 16'd9, "R11");
        chk("R11", "pwm_b unchanged by unmapped write", pwm_b, 1'b0);
        // R8 reload at zero only; R6 force high on A
        wr(3'd4, 16'h0002, "R6");
        tk(1'b0, 1'b1, 1'b1, 16'd7, "R8");
        tk(1'b0, 1'b0, 1'b1, 16'd4, "R8");
        chk("R8", "pwm_a not yet forced", pwm_a, 1'b0);
        tk(1'b1, 1'b0, 1'b1, 16'd0, "R8");
        chk("R6", "pwm_a forced high", pwm_a, 1'b1);
        // R7 compare low action overridden, level evolves underneath
        tk(1'b0, 1'b0, 1'b1, 16'd4, "R7");
        chk("R7", "pwm_a still forced", pwm_a, 1'b1);
        // R9 immediate reload: release at next tick shows event level (low)
        wr(3'd5, 16'h00C0, "R9");
        wr(3'd4, 16'h0003, "R9");
        tk(1'b0, 1'b0, 1'b1, 16'd9, "R9");
        chk("R7", "pwm_a released to event level", pwm_a, 1'b0);
        wr(3'd4, 16'h0008, "R9");
        tk(1'b0, 1'b0, 1'b1, 16'd9, "R9");
        chk("R9", "pwm_b forced at first tick", pwm_b, 1'b1);
        wr(3'd4, 16'h0000, "R6");
        tk(1'b0, 1'b0, 1'b1, 16'd9, "R6");

        // R4 sweep over all code combinations and event mixes
        wr(3'd0, 16'd4, "R4");
        wr(3'd1, 16'd8, "R4");
        for (int v = 0; v < 256; v++) begin
            logic [9:0] aa, ab;
            aa = {v[7:6], 2'b00, v[5:0]};
            ab = {v[1:0], 2'b00, v[7:2]};
            wr(3'd2, {6'd0, aa}, "R4");
            wr(3'd3, {6'd0, ab}, "R4");
            if (v == 128) wr(3'd1, 16'd4, "R4");
            for (int e = 0; e < 16; e++) begin
                logic [15:0] cv;
                logic up;
                case (e[3:2])
                    2'd0: begin cv = 16'd1; up = 1'b1; end
                    2'd1: begin cv = 16'd4; up = 1'b1; end
                    2'd2: begin cv = 16'd8; up = 1'b1; end
                    default: begin cv = 16'd4; up = 1'b0; end
                endcase
                tk(e[0], e[1], up, cv, "R4");
            end
        end

        // random mix of events, overrides and reload codes (R8)
        void'($urandom(1234));
        for (int i = 0; i < 20000; i++) begin
            logic [31:0] r;
            logic [2:0] a;
            logic [15:0] d;
            r = $urandom;
            a = 3'(r[10:8] % 6);
            case (a)
                3'd0, 3'd1: d = r[16] ? 16'd4 : 16'd8;
                default:    d = r[31:16];
            endcase
            step(r[7:4] == 4'd0, a, d, r[1:0] != 2'b00, r[2], r[3],
                 r[11], {12'd0, r[15:12] & 4'hC}, "R8");
            if (i == 12000) do_reset();
        end

        do_reset();
        tk(1'b1, 1'b1, 1'b1, 16'd0, "R10");
        chk("R10", "pwm_a stays low after reset", pwm_a, 1'b0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule